// File: doc/BRIEF.md
# Boot ROM Chip-Select Decoder

This block sits on the host memory request path and decides, one request at a time, whether the address falls in the boot ROM region. When it does, the block claims the cycle and drives an ISA-style memory cycle toward the ROM with the active-low ROM chip select asserted. Two windows are always decoded: a 64 KB window just below the 1 MB line and a 256 KB window at the top of the 4 GB space. Two wider windows can be enabled by configuration: 128 KB below the 1 MB line and 16 MB at the top of memory.

Writes are normally absorbed without touching the ROM. A flash-write enable lets writes reach the device with the chip select and both write strobes asserted, so flash parts can be programmed. The ROM data width (8 or 16 bits) is taken from a strap input while reset is held. Software can then override it through a set strobe, and the override holds until the next reset.

All outputs are registered. Each output reflects the request presented on the previous clock edge, and it is held for as long as the request stays valid and unchanged.

Top module: `boot_rom_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rom_claim` is 0 and `rom_cs_n`, `mem_rd_n`, `mem_wr_n`, `wr_n` are all 1.
- R2: With both wide enables clear, a valid read to any address in 000F0000h–000FFFFFh or FFFC0000h–FFFFFFFFh produces `rom_claim`=1 one clock later.
- R3: Addresses 000E0000h–000EFFFFh are claimed only while `cfg_lo_wide_en`=1. Addresses FF000000h–FFFBFFFFh are claimed only while `cfg_hi_wide_en`=1.
- R4: A request outside every enabled window, or any cycle with `req_valid`=0, gives `rom_claim`=0 and all four strobes at 1 on the next clock.
- R5: A claimed read (`req_write`=0) drives `rom_cs_n`=0 and `mem_rd_n`=0, with `mem_wr_n`=1 and `wr_n`=1.
- R6: A claimed write with `cfg_flash_we`=0 keeps `rom_claim`=1 but leaves `rom_cs_n`, `mem_rd_n`, `mem_wr_n` and `wr_n` all at 1.
- R7: A claimed write with `cfg_flash_we`=1 drives `rom_cs_n`=0, `mem_wr_n`=0 and `wr_n`=0, with `mem_rd_n`=1.
- R8: `rom_width16` (1 = 16-bit ROM, 0 = 8-bit) equals the value `strap_width16` had on the last clock edge with `rst` high. It is visible from the first cycle after reset.
- R9: After reset, a cycle with `cfg_width_set`=1 loads `cfg_width_val` into `rom_width16` on that clock edge. The loaded value holds until the next set or the next reset, whatever the strap does.
- R10: The outputs are registered with one clock of latency and stay constant while `req_valid` and the request stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host memory request valid |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_lo_wide_en | input | 1 | Enables the 128 KB window below 1 MB |
| cfg_hi_wide_en | input | 1 | Enables the 16 MB window at the top of memory |
| cfg_flash_we | input | 1 | Lets writes reach the ROM |
| cfg_width_set | input | 1 | Software width load strobe |
| cfg_width_val | input | 1 | Width value to load (1 = 16-bit) |
| strap_width16 | input | 1 | Width strap captured during reset |
| rom_claim | output | 1 | Cycle claimed by the ROM decoder |
| rom_cs_n | output | 1 | ROM chip select, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| wr_n | output | 1 | Generic write strobe, active low |
| rom_width16 | output | 1 | Current ROM width, 1 = 16-bit |

## Verification
A faulty window comparison shows up one clock after the offending request: a boundary address is claimed when it should not be, or left unclaimed when it should be. For this reason the stimulus walks the first and last address of every window and the addresses on each side of it. A stuck width register or a lost override shows on `rom_width16` in the cycle after reset ends or after the set strobe. A strobe decoded for the wrong request type shows on the same clock as the claim. Because the reference model is compared on every clock, each of these faults is caught within one cycle of when it first becomes visible.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

  localparam int ADDR_W  = 32;
  localparam int NUM_WIN = 4;

  // Index of each decode window in the hit vector
  localparam int WIN_LO      = 0;
  localparam int WIN_LO_WIDE = 1;
  localparam int WIN_HI      = 2;
  localparam int WIN_HI_WIDE = 3;

  typedef struct packed {
    logic claim;
    logic cs_n;
    logic rd_n;
    logic mw_n;
    logic wr_n;
  } isa_strobe_t;

  function automatic isa_strobe_t idle_strobes();
    isa_strobe_t s;
    s.claim = 1'b0;
    s.cs_n  = 1'b1;
    s.rd_n  = 1'b1;
    s.mw_n  = 1'b1;
    s.wr_n  = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/boot_rom_window.sv
module boot_rom_window #(
  parameter int               AW        = 32,
  parameter logic [AW-1:0]    BASE      = '0,
  parameter int               SPAN_BITS = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  output logic          hit
);
  // Upper bits above the window span must equal the base
  localparam logic [AW-1:0] CMP_MASK = ~((AW'(1) << SPAN_BITS) - AW'(1));

  always_comb begin
    hit = en && (((addr ^ BASE) & CMP_MASK) == '0);
  end
endmodule

// File: rtl/boot_rom_addr_decode.sv
module boot_rom_addr_decode #(
  parameter int            AW           = 32,
  parameter logic [AW-1:0] LO_BASE      = 32'h000F_0000,
  parameter int            LO_SPAN      = 16,
  parameter logic [AW-1:0] LO_WIDE_BASE = 32'h000E_0000,
  parameter int            LO_WIDE_SPAN = 17,
  parameter logic [AW-1:0] HI_BASE      = 32'hFFFC_0000,
  parameter int            HI_SPAN      = 18,
  parameter logic [AW-1:0] HI_WIDE_BASE = 32'hFF00_0000,
  parameter int            HI_WIDE_SPAN = 24
) (
  input  logic [AW-1:0] addr,
  input  logic          lo_wide_en,
  input  logic          hi_wide_en,
  output logic          hit
);
  import boot_rom_pkg::*;

  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_hit;

  always_comb begin
    win_en              = '0;
    win_en[WIN_LO]      = 1'b1;
    win_en[WIN_HI]      = 1'b1;
    win_en[WIN_LO_WIDE] = lo_wide_en;
    win_en[WIN_HI_WIDE] = hi_wide_en;
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [AW-1:0] W_BASE =
      (i == WIN_LO)      ? LO_BASE      :
      (i == WIN_LO_WIDE) ? LO_WIDE_BASE :
      (i == WIN_HI)      ? HI_BASE      : HI_WIDE_BASE;
    localparam int W_SPAN =
      (i == WIN_LO)      ? LO_SPAN      :
      (i == WIN_LO_WIDE) ? LO_WIDE_SPAN :
      (i == WIN_HI)      ? HI_SPAN      : HI_WIDE_SPAN;

    boot_rom_window #(
      .AW        (AW),
      .BASE      (W_BASE),
      .SPAN_BITS (W_SPAN)
    ) u_win (
      .addr (addr),
      .en   (win_en[i]),
      .hit  (win_hit[i])
    );
  end

  always_comb begin
    hit = |win_hit;
  end
endmodule

// File: rtl/boot_rom_width_reg.sv
module boot_rom_width_reg (
  input  logic clk,
  input  logic rst,
  input  logic strap,
  input  logic set,
  input  logic set_val,
  output logic width16
);
  // Strap followed while reset is held; last sampled value survives release
  always_ff @(posedge clk) begin
    if (rst) begin
      width16 <= strap;
    end else if (set) begin
      width16 <= set_val;
    end
  end
endmodule

// File: rtl/boot_rom_strobe_gen.sv
module boot_rom_strobe_gen (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid,
  input  logic                      write,
  input  logic                      hit,
  input  logic                      flash_we,
  output boot_rom_pkg::isa_strobe_t strb
);
  import boot_rom_pkg::*;

  isa_strobe_t nxt;

  always_comb begin
    nxt = idle_strobes();
    if (valid && hit) begin
      nxt.claim = 1'b1;
      if (!write) begin
        nxt.cs_n = 1'b0;
        nxt.rd_n = 1'b0;
      end else if (flash_we) begin
        nxt.cs_n = 1'b0;
        nxt.mw_n = 1'b0;
        nxt.wr_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= idle_strobes();
    end else begin
      strb <= nxt;
    end
  end
endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder #(
  parameter int                ADDR_W       = boot_rom_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] LO_BASE      = 32'h000F_0000,
  parameter int                LO_SPAN      = 16,
  parameter logic [ADDR_W-1:0] LO_WIDE_BASE = 32'h000E_0000,
  parameter int                LO_WIDE_SPAN = 17,
  parameter logic [ADDR_W-1:0] HI_BASE      = 32'hFFFC_0000,
  parameter int                HI_SPAN      = 18,
  parameter logic [ADDR_W-1:0] HI_WIDE_BASE = 32'hFF00_0000,
  parameter int                HI_WIDE_SPAN = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              cfg_lo_wide_en,
  input  logic              cfg_hi_wide_en,
  input  logic              cfg_flash_we,
  input  logic              cfg_width_set,
  input  logic              cfg_width_val,
  input  logic              strap_width16,
  output logic              rom_claim,
  output logic              rom_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              wr_n,
  output logic              rom_width16
);
  import boot_rom_pkg::*;

  logic        addr_hit;
  isa_strobe_t strb;

  boot_rom_addr_decode #(
    .AW           (ADDR_W),
    .LO_BASE      (LO_BASE),
    .LO_SPAN      (LO_SPAN),
    .LO_WIDE_BASE (LO_WIDE_BASE),
    .LO_WIDE_SPAN (LO_WIDE_SPAN),
    .HI_BASE      (HI_BASE),
    .HI_SPAN      (HI_SPAN),
    .HI_WIDE_BASE (HI_WIDE_BASE),
    .HI_WIDE_SPAN (HI_WIDE_SPAN)
  ) u_dec (
    .addr       (req_addr),
    .lo_wide_en (cfg_lo_wide_en),
    .hi_wide_en (cfg_hi_wide_en),
    .hit        (addr_hit)
  );

  boot_rom_strobe_gen u_strb (
    .clk      (clk),
    .rst      (rst),
    .valid    (req_valid),
    .write    (req_write),
    .hit      (addr_hit),
    .flash_we (cfg_flash_we),
    .strb     (strb)
  );

  boot_rom_width_reg u_width (
    .clk     (clk),
    .rst     (rst),
    .strap   (strap_width16),
    .set     (cfg_width_set),
    .set_val (cfg_width_val),
    .width16 (rom_width16)
  );

  assign rom_claim = strb.claim;
  assign rom_cs_n  = strb.cs_n;
  assign mem_rd_n  = strb.rd_n;
  assign mem_wr_n  = strb.mw_n;
  assign wr_n      = strb.wr_n;
endmodule

// File: rtl/boot_rom_decoder_chk.sv
module boot_rom_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic        cfg_lo_wide_en,
  input logic        cfg_hi_wide_en,
  input logic        cfg_flash_we,
  input logic        cfg_width_set,
  input logic        cfg_width_val,
  input logic        strap_width16,
  input logic        rom_claim,
  input logic        rom_cs_n,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        wr_n,
  input logic        rom_width16
);
  // R1: reset drives the idle state
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rom_claim && rom_cs_n && mem_rd_n && mem_wr_n && wr_n));

  // R2: top-of-memory base window read is claimed
  a_r2_hi_read_claim: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (req_addr[31:18] == 14'h3FFF)) |=> (rom_claim && !mem_rd_n));

  // R3: wide low window ignored while disabled
  a_r3_lo_wide_gated: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_lo_wide_en && (req_addr[31:16] == 16'h000E)) |=> !rom_claim);

  // R3: wide high window ignored while disabled
  a_r3_hi_wide_gated: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_hi_wide_en && (req_addr[31:24] == 8'hFF) && (req_addr[23:18] != 6'h3F))
      |=> !rom_claim);

  // R4: no request gives no cycle
  a_r4_idle_when_invalid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rom_claim && rom_cs_n && mem_rd_n && mem_wr_n && wr_n));

  // R5: read strobe pattern
  a_r5_read_pattern: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (rom_claim && !rom_cs_n && mem_wr_n && wr_n));

  // R6: suppressed writes keep every strobe high
  a_r6_write_suppressed: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !cfg_flash_we) |=> (rom_cs_n && mem_wr_n && wr_n && mem_rd_n));

  // R7: flash write strobe pattern
  a_r7_write_pattern: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> (rom_claim && !rom_cs_n && !wr_n && mem_rd_n));

  // R8: strap captured while reset is held
  a_r8_strap_capture: assert property (@(posedge clk)
    rst |=> (rom_width16 == $past(strap_width16)));

  // R9: software load takes effect
  a_r9_width_load: assert property (@(posedge clk) disable iff (rst)
    cfg_width_set |=> (rom_width16 == $past(cfg_width_val)));

  // R9: width holds without a load
  a_r9_width_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_width_set |=> $stable(rom_width16));
endmodule

bind boot_rom_decoder boot_rom_decoder_chk u_chk (.*);

// File: tb/tb_boot_rom_decoder.sv
module tb_boot_rom_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        cfg_lo_wide_en = 1'b0;
  logic        cfg_hi_wide_en = 1'b0;
  logic        cfg_flash_we = 1'b0;
  logic        cfg_width_set = 1'b0;
  logic        cfg_width_val = 1'b0;
  logic        strap_width16 = 1'b1;
  logic        rom_claim, rom_cs_n, mem_rd_n, mem_wr_n, wr_n, rom_width16;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_rom_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .cfg_lo_wide_en(cfg_lo_wide_en),
    .cfg_hi_wide_en(cfg_hi_wide_en), .cfg_flash_we(cfg_flash_we),
    .cfg_width_set(cfg_width_set), .cfg_width_val(cfg_width_val),
    .strap_width16(strap_width16), .rom_claim(rom_claim), .rom_cs_n(rom_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .wr_n(wr_n), .rom_width16(rom_width16)
  );

  // Behavioural reference model
  logic e_claim = 1'b0, e_cs = 1'b1, e_rd = 1'b1, e_mw = 1'b1, e_wr = 1'b1, e_w16 = 1'b0;

  function automatic bit in_rom(logic [31:0] a, logic lo_w, logic hi_w);
    bit h;
    h = (a >= 32'h000F_0000 && a <= 32'h000F_FFFF) || (a >= 32'hFFFC_0000);
    if (lo_w && a >= 32'h000E_0000 && a <= 32'h000F_FFFF) h = 1;
    if (hi_w && a >= 32'hFF00_0000) h = 1;
    return h;
  endfunction

  always @(posedge clk) begin
    bit claimed;
    if (rst) begin
      e_claim <= 0; e_cs <= 1; e_rd <= 1; e_mw <= 1; e_wr <= 1;
      e_w16   <= strap_width16;
    end else begin
      claimed = req_valid && in_rom(req_addr, cfg_lo_wide_en, cfg_hi_wide_en);
      e_claim <= claimed;
      e_cs <= !(claimed && (!req_write || cfg_flash_we));
      e_rd <= !(claimed && !req_write);
      e_mw <= !(claimed && req_write && cfg_flash_we);
      e_wr <= !(claimed && req_write && cfg_flash_we);
      if (cfg_width_set) e_w16 <= cfg_width_val;
    end
  end

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 0;

  // Compare every output on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if ({rom_claim, rom_cs_n, mem_rd_n, mem_wr_n, wr_n, rom_width16} !==
          {e_claim, e_cs, e_rd, e_mw, e_wr, e_w16}) begin
        n_fail++;
        $display("FAIL %s t=%0t addr=%h claim/cs/rd/mw/wr/w16 actual=%b%b%b%b%b%b expected=%b%b%b%b%b%b",
                 tag, $time, req_addr, rom_claim, rom_cs_n, mem_rd_n, mem_wr_n, wr_n, rom_width16,
                 e_claim, e_cs, e_rd, e_mw, e_wr, e_w16);
      end
    end
  end

  task automatic access(input logic v, input logic [31:0] a, input logic w);
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1; strap_width16 = strap;
    repeat (3) @(negedge clk);
    rst = 0;
    strap_width16 = ~strap;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    strap_width16 = 0;
    tag = "R8";
    repeat (2) @(negedge clk);

    tag = "R2";
    access(1, 32'h000F_0000, 0);
    access(1, 32'h000F_FFFF, 0);
    access(1, 32'hFFFC_0000, 0);
    access(1, 32'hFFFF_FFFF, 0);

    tag = "R4";
    access(1, 32'h000E_FFFF, 0);
    access(1, 32'hFFFB_FFFF, 0);
    access(1, 32'h0010_0000, 0);
    access(1, 32'h0000_0000, 0);
    access(0, 32'h000F_1234, 0);

    tag = "R3";
    access(1, 32'h000E_0000, 0);
    access(1, 32'hFF00_0000, 0);
    cfg_lo_wide_en = 1;
    access(1, 32'h000E_0000, 0);
    access(1, 32'h000D_FFFF, 0);
    cfg_hi_wide_en = 1;
    access(1, 32'hFF00_0000, 0);
    access(1, 32'hFEFF_FFFF, 0);
    access(1, 32'hFFFB_0000, 0);
    cfg_lo_wide_en = 0; cfg_hi_wide_en = 0;

    tag = "R5";
    access(1, 32'h000F_8000, 0);

    tag = "R6";
    access(1, 32'h000F_8000, 1);
    access(1, 32'hFFFE_0000, 1);

    tag = "R7";
    cfg_flash_we = 1;
    access(1, 32'h000F_8000, 1);
    access(1, 32'hFFFE_0000, 1);
    access(1, 32'h0020_0000, 1);
    cfg_flash_we = 0;

    tag = "R10";
    @(negedge clk);
    req_valid = 1; req_addr = 32'hFFFD_0000; req_write = 0;
    repeat (5) @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);

    tag = "R9";
    @(negedge clk);
    cfg_width_set = 1; cfg_width_val = 1;
    @(negedge clk);
    cfg_width_set = 0; cfg_width_val = 0;
    repeat (3) @(negedge clk);
    cfg_width_set = 1; cfg_width_val = 0;
    @(negedge clk);
    cfg_width_set = 0; cfg_width_val = 1;
    repeat (2) @(negedge clk);

    tag = "R8";
    do_reset(1);
    repeat (3) @(negedge clk);
    do_reset(0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule